// File: doc/BRIEF.md
# DDR2 Extended Mode Register Command Guard

This block sits beside a DDR2 memory controller's command scheduler. It keeps a shadow copy of the extended mode register, which it captures whenever the controller issues a load of that register. It decodes the copy into status outputs: DLL state, termination value, drive strength, strobe configuration and output disable.

It also watches the command stream and the on-die termination request, and applies three timing guards. A READ is held back until the DLL has had time to lock after a reset. The outgoing termination pin stays low during a settle window after termination is switched on. The termination pin is gated by power state, so it is passed through only in the states where the memory honours it.

When the controller forces an early READ, enters self refresh with termination asserted, or writes a termination code that the build treats as reserved, the block sets a sticky error flag. The flag stays set until the clear input is pulsed.

Top module: `ddr2_emr_guard`

Command encoding on `cmd`:
- `0` is no operation.
- `1` loads the extended register from `cmd_data`.
- `2` is a DLL reset, issued through the primary mode register.
- `3` enters self refresh.
- `4` exits self refresh.

Power state encoding on `pwr_state`:
- `00` is active.
- `01` is active power-down.
- `10` is precharge power-down.
- `11` is any other state.

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every error flag is 0, the shadow register is 0, `dll_locked` is 0, `odt_out` is 0 and `rtt_code` is 00.
- R2: The strobe and output fields decode as follows. `out_disabled` equals shadow bit 12. `drive_reduced` equals bit 1. `dqs_single_ended` equals bit 10. `rdqs_n_enabled` is 1 only when bit 11 is 1 and bit 10 is 0.
- R3: `rtt_code` equals {bit 6, bit 2} of the shadow. The codes are 00 off, 01 75 ohm, 10 150 ohm and 11 50 ohm.
- R4: `rd_grant` equals `rd_req` only when three conditions hold. The DLL must be enabled (bit 0 is 0 and the block is not in self refresh). A DLL reset must have been accepted since the DLL was last disabled. At least 200 cycles must separate that reset's clock edge from the current edge. In all other cases `rd_grant` is 0.
- R5: A `rd_force` sampled while `dll_locked` is 0 sets `err_rd_early` at that edge.
- R6: Entering self refresh disables the DLL and clears lock. Exiting self refresh with bit 0 equal to 0 re-arms the DLL and restarts the 200-cycle lockout from the exit edge.
- R7: A load with bit 0 equal to 1 disables the DLL. A later load with bit 0 equal to 0 does not end the lockout. Only a following DLL reset and its 200 cycles do.
- R8: A load with a non-zero termination code holds `odt_out` low for the 8 cycles that follow the load edge.
- R9: `odt_out` equals `odt_in` only under all of these conditions: `pwr_state` is not 11, the block is not in self refresh, `rtt_code` is not 00, and no settle window is open. Otherwise `odt_out` is 0.
- R10: A self-refresh entry command sampled while `odt_in` is 1 sets `err_odt_sr`.
- R11: With parameter ALLOW_50 = 0, a load with bits 6 and 2 both 1 sets `err_rsvd`, and `rtt_code` reads 00 (off).
- R12: An error flag stays set until `err_clr` is sampled high. The flag clears at that edge unless its own set condition occurs at the same edge, in which case the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_clr | input | 1 | Clears all error flags |
| cmd | input | 3 | Command code |
| cmd_data | input | 13 | Register value carried by a load |
| rd_req | input | 1 | READ request, held back during lockout |
| rd_force | input | 1 | READ issued regardless of lockout |
| odt_in | input | 1 | Termination request from the controller |
| pwr_state | input | 2 | Current power state of the memory |
| rd_grant | output | 1 | READ may be issued this cycle |
| odt_out | output | 1 | Gated termination pin |
| dll_enabled | output | 1 | DLL enabled and not in self refresh |
| dll_locked | output | 1 | READ lockout has ended |
| rtt_code | output | 2 | Effective termination code |
| drive_reduced | output | 1 | Reduced output drive selected |
| dqs_single_ended | output | 1 | Single-ended strobe selected |
| rdqs_n_enabled | output | 1 | Complementary read strobe enabled |
| out_disabled | output | 1 | Data and strobe outputs disabled |
| err_rd_early | output | 1 | Sticky: READ forced during lockout |
| err_odt_sr | output | 1 | Sticky: self-refresh entry with termination high |
| err_rsvd | output | 1 | Sticky: reserved termination code written |

## Verification
The assertions assume the following about the inputs:
- `cmd` carries only the five defined codes.
- `rd_force` is used only as a deliberate violation.
- Loads during self refresh do not occur.

The stimulus keeps to these limits by issuing each command as a single-cycle pulse on an otherwise idle bus. It leaves the bus idle while in self refresh, and it issues self-refresh exit only after a matching entry. It drives `odt_in` high across loads and power-state changes on purpose, so that the gating and the settle window are exercised rather than assumed.

// File: rtl/ddr2_emr_guard.sv
module ddr2_emr_guard #(
  parameter int LOCK_CYCLES = 200,
  parameter int ODT_SETTLE  = 8,
  parameter bit ALLOW_50    = 1'b1,
  parameter int EMR_W       = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_clr,
  input  logic [2:0]       cmd,
  input  logic [EMR_W-1:0] cmd_data,
  input  logic             rd_req,
  input  logic             rd_force,
  input  logic             odt_in,
  input  logic [1:0]       pwr_state,
  output logic             rd_grant,
  output logic             odt_out,
  output logic             dll_enabled,
  output logic             dll_locked,
  output logic [1:0]       rtt_code,
  output logic             drive_reduced,
  output logic             dqs_single_ended,
  output logic             rdqs_n_enabled,
  output logic             out_disabled,
  output logic             err_rd_early,
  output logic             err_odt_sr,
  output logic             err_rsvd
);
  localparam logic [2:0] C_LOAD = 3'd1, C_DLLRST = 3'd2, C_SR_IN = 3'd3, C_SR_OUT = 3'd4;
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam int OW = $clog2(ODT_SETTLE + 1);
  localparam logic [LW-1:0] LOCK_LOAD = LW'(LOCK_CYCLES - 1);
  localparam logic [OW-1:0] ODT_LOAD  = OW'(ODT_SETTLE);

  logic [EMR_W-1:0] emr;
  logic             in_sr, armed;
  logic [LW-1:0]    lock_cnt;
  logic [OW-1:0]    odt_cnt;
  logic [1:0]       new_rtt;
  logic             new_rsvd;

  generate
    if (ALLOW_50) begin : g_rtt50
      assign rtt_code = {emr[6], emr[2]};
      assign new_rtt  = {cmd_data[6], cmd_data[2]};
      assign new_rsvd = 1'b0;
    end else begin : g_rttrsv
      assign rtt_code = (emr[6] & emr[2]) ? 2'b00 : {emr[6], emr[2]};
      assign new_rtt  = (cmd_data[6] & cmd_data[2]) ? 2'b00 : {cmd_data[6], cmd_data[2]};
      assign new_rsvd = cmd_data[6] & cmd_data[2];
    end
  endgenerate

  assign dll_enabled      = ~emr[0] & ~in_sr;
  assign dll_locked       = armed & dll_enabled & (lock_cnt == '0);
  assign rd_grant         = rd_req & dll_locked;
  assign odt_out          = odt_in & (pwr_state != 2'b11) & ~in_sr &
                            (rtt_code != 2'b00) & (odt_cnt == '0);
  assign drive_reduced    = emr[1];
  assign dqs_single_ended = emr[10];
  assign rdqs_n_enabled   = emr[11] & ~emr[10];
  assign out_disabled     = emr[12];

  always_ff @(posedge clk) begin
    if (rst) begin
      emr          <= '0;
      in_sr        <= 1'b0;
      armed        <= 1'b0;
      lock_cnt     <= '0;
      odt_cnt      <= '0;
      err_rd_early <= 1'b0;
      err_odt_sr   <= 1'b0;
      err_rsvd     <= 1'b0;
    end else begin
      if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
      if (odt_cnt != '0)  odt_cnt  <= odt_cnt - 1'b1;
      case (cmd)
        C_LOAD: begin
          emr <= cmd_data;
          if (cmd_data[0]) armed <= 1'b0;
          if (new_rtt != 2'b00) odt_cnt <= ODT_LOAD;
        end
        C_DLLRST: if (dll_enabled) begin
          armed    <= 1'b1;
          lock_cnt <= LOCK_LOAD;
        end
        C_SR_IN: if (!in_sr) begin
          in_sr <= 1'b1;
          armed <= 1'b0;
        end
        C_SR_OUT: if (in_sr) begin
          in_sr <= 1'b0;
          if (!emr[0]) begin
            armed    <= 1'b1;
            lock_cnt <= LOCK_LOAD;
          end
        end
        default: ;
      endcase
      err_rd_early <= (err_rd_early & ~err_clr) | (rd_force & ~dll_locked);
      err_odt_sr   <= (err_odt_sr & ~err_clr) | ((cmd == C_SR_IN) & odt_in);
      err_rsvd     <= (err_rsvd & ~err_clr) | ((cmd == C_LOAD) & new_rsvd);
    end
  end
endmodule

module ddr2_emr_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       err_clr,
  input logic [2:0] cmd,
  input logic [12:0] cmd_data,
  input logic       rd_req,
  input logic       rd_force,
  input logic       odt_in,
  input logic [1:0] pwr_state,
  input logic       rd_grant,
  input logic       odt_out,
  input logic       dll_enabled,
  input logic       dll_locked,
  input logic       err_rd_early,
  input logic       err_odt_sr
);
  a_r4_grant_needs_dll: assert property (@(posedge clk) disable iff (rst)
    rd_grant |-> rd_req && dll_enabled);
  a_r4_reset_starts_lockout: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd2) |=> !dll_locked);
  a_r5_forced_read_flags: assert property (@(posedge clk) disable iff (rst)
    (rd_force && !dll_locked) |=> err_rd_early);
  a_r6_sr_entry_unlocks: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd3) |=> !dll_locked && !odt_out && !dll_enabled);
  a_r7_dll_off_load: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd1 && cmd_data[0]) |=> !dll_locked && !dll_enabled);
  a_r8_settle_after_load: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd1 && (cmd_data[6] || cmd_data[2])) |=> !odt_out);
  a_r9_other_state_blocks: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'b11) |-> !odt_out);
  a_r9_follows_request: assert property (@(posedge clk) disable iff (rst)
    odt_out |-> odt_in);
  a_r10_sr_with_odt: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd3 && odt_in) |=> err_odt_sr);
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_rd_early && !err_clr) |=> err_rd_early);
endmodule

bind ddr2_emr_guard ddr2_emr_guard_chk u_chk (
  .clk(clk), .rst(rst), .err_clr(err_clr), .cmd(cmd), .cmd_data(cmd_data),
  .rd_req(rd_req), .rd_force(rd_force), .odt_in(odt_in), .pwr_state(pwr_state),
  .rd_grant(rd_grant), .odt_out(odt_out), .dll_enabled(dll_enabled),
  .dll_locked(dll_locked), .err_rd_early(err_rd_early), .err_odt_sr(err_odt_sr)
);

// File: tb/ddr2_emr_guard_tb_top.sv
`timescale 1ns/1ps
module ddr2_emr_guard_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, err_clr = 1'b0, rd_req = 1'b0, rd_force = 1'b0, odt_in = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [12:0] cmd_data = '0;
  logic [1:0] pwr_state = 2'b00;

  logic rd_grant, odt_out, dll_enabled, dll_locked, drive_reduced, dqs_single_ended;
  logic rdqs_n_enabled, out_disabled, err_rd_early, err_odt_sr, err_rsvd;
  logic [1:0] rtt_code;
  logic r_grant, r_odt, r_dlle, r_lock, r_drv, r_se, r_rn, r_dis, r_erd, r_eodt, r_ersv;
  logic [1:0] r_rtt;

  ddr2_emr_guard dut_i (
    .clk(clk), .rst(rst), .err_clr(err_clr), .cmd(cmd), .cmd_data(cmd_data),
    .rd_req(rd_req), .rd_force(rd_force), .odt_in(odt_in), .pwr_state(pwr_state),
    .rd_grant(rd_grant), .odt_out(odt_out), .dll_enabled(dll_enabled),
    .dll_locked(dll_locked), .rtt_code(rtt_code), .drive_reduced(drive_reduced),
    .dqs_single_ended(dqs_single_ended), .rdqs_n_enabled(rdqs_n_enabled),
    .out_disabled(out_disabled), .err_rd_early(err_rd_early),
    .err_odt_sr(err_odt_sr), .err_rsvd(err_rsvd));

  ddr2_emr_guard #(.ALLOW_50(1'b0)) dut_r (
    .clk(clk), .rst(rst), .err_clr(err_clr), .cmd(cmd), .cmd_data(cmd_data),
    .rd_req(rd_req), .rd_force(rd_force), .odt_in(odt_in), .pwr_state(pwr_state),
    .rd_grant(r_grant), .odt_out(r_odt), .dll_enabled(r_dlle), .dll_locked(r_lock),
    .rtt_code(r_rtt), .drive_reduced(r_drv), .dqs_single_ended(r_se),
    .rdqs_n_enabled(r_rn), .out_disabled(r_dis), .err_rd_early(r_erd),
    .err_odt_sr(r_eodt), .err_rsvd(r_ersv));

  int checks = 0, errors = 0;
  bit done = 0;
  // reference model state
  int cyc = 0, m_rst_cyc = -1000, m_odt_cyc = -1000;
  logic [12:0] m_emr = '0;
  bit m_sr = 0, m_armed = 0, m_erd = 0, m_eodt = 0, m_ersv = 0;

  function automatic bit m_locked();
    return m_armed && !m_emr[0] && !m_sr && (cyc - m_rst_cyc >= 200);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit lk = m_locked();
    logic [1:0] rt = {m_emr[6], m_emr[2]};
    bit oe = odt_in && pwr_state != 2'b11 && !m_sr && rt != 2'b00 && (cyc - m_odt_cyc > 8);
    chk("R2", "out_disabled", out_disabled, m_emr[12]);
    chk("R2", "drive_reduced", drive_reduced, m_emr[1]);
    chk("R2", "dqs_single_ended", dqs_single_ended, m_emr[10]);
    chk("R2", "rdqs_n_enabled", rdqs_n_enabled, m_emr[11] && !m_emr[10]);
    chk("R3", "rtt_code", rtt_code, rt);
    chk("R6", "dll_enabled", dll_enabled, !m_emr[0] && !m_sr);
    chk("R4", "dll_locked", dll_locked, lk);
    chk("R4", "rd_grant", rd_grant, rd_req && lk);
    chk("R9", "odt_out", odt_out, oe);
    chk("R5", "err_rd_early", err_rd_early, m_erd);
    chk("R10", "err_odt_sr", err_odt_sr, m_eodt);
    chk("R11", "err_rsvd", r_ersv, m_ersv);
    chk("R11", "rtt_code_rsv", r_rtt, (rt == 2'b11) ? 0 : rt);
    chk("R12", "err_rsvd_default", err_rsvd, 0);
  endtask

  task automatic model_edge();
    bit lk = m_locked();
    if (rst) begin
      m_emr = '0; m_sr = 0; m_armed = 0; m_erd = 0; m_eodt = 0; m_ersv = 0;
      m_rst_cyc = -1000; m_odt_cyc = -1000;
    end else begin
      m_erd  = (m_erd && !err_clr) || (rd_force && !lk);
      m_eodt = (m_eodt && !err_clr) || (cmd == 3'd3 && odt_in);
      m_ersv = (m_ersv && !err_clr) || (cmd == 3'd1 && cmd_data[6] && cmd_data[2]);
      case (cmd)
        3'd1: begin
          m_emr = cmd_data;
          if (cmd_data[0]) m_armed = 0;
          if (cmd_data[6] || cmd_data[2]) m_odt_cyc = cyc;
        end
        3'd2: if (!m_emr[0] && !m_sr) begin m_armed = 1; m_rst_cyc = cyc; end
        3'd3: if (!m_sr) begin m_sr = 1; m_armed = 0; end
        3'd4: if (m_sr) begin
          m_sr = 0;
          if (!m_emr[0]) begin m_armed = 1; m_rst_cyc = cyc; end
        end
        default: ;
      endcase
    end
    cyc++;
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      #2;
      compare();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      cmd = 3'd0; err_clr = 1'b0; rd_force = 1'b0;
    end
  endtask

  task automatic issue(logic [2:0] c, logic [12:0] d = '0);
    cmd = c; cmd_data = d;
    step(1);
  endtask

  initial begin
    #50000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(2);                                  // R1 reset state compared while rst high
    rst = 1'b0;
    step(1);                                  // R1 state after release
    chk("R1", "dll_locked_after_reset", dll_locked, 0);
    // R2/R3 decode patterns
    issue(3'd1, 13'h1402);                    // E12,E10,E1
    issue(3'd1, 13'h0840);                    // E11,E6 -> rtt 10
    issue(3'd1, 13'h0C04);                    // E11,E10,E2 -> rtt 01
    issue(3'd1, 13'h0044);                    // rtt 11: R11 reserved on dut_r
    step(2);
    err_clr = 1'b1; step(1);                  // R12 clear
    // R4 lockout with continuous request
    rd_req = 1'b1;
    issue(3'd2);
    step(50);
    rd_force = 1'b1; step(1);                 // R5 forced early read
    step(145);
    err_clr = 1'b1; rd_force = 1'b1; step(1); // R12 set wins over clear
    step(10);                                 // crosses the 200-cycle boundary
    chk("R4", "grant_after_lockout", rd_grant, 1);
    err_clr = 1'b1; step(1);
    rd_force = 1'b1; step(1);                 // locked: no error
    // R8/R9 termination
    odt_in = 1'b1;
    issue(3'd1, 13'h0004);
    step(12);
    pwr_state = 2'b01; step(2);
    pwr_state = 2'b10; step(2);
    pwr_state = 2'b11; step(2);
    pwr_state = 2'b00; step(1);
    issue(3'd1, 13'h0000);                    // rtt off
    step(3);
    issue(3'd1, 13'h0040);
    step(10);
    // R10/R6 self refresh with termination high
    issue(3'd3);
    step(5);
    odt_in = 1'b0;
    issue(3'd4);
    step(205);
    err_clr = 1'b1; step(1);
    // R6 clean self refresh entry
    issue(3'd3);
    step(3);
    issue(3'd4);
    step(202);
    // R7 DLL disable and re-enable
    issue(3'd1, 13'h0041);
    step(5);
    issue(3'd1, 13'h0040);
    step(210);
    chk("R7", "no_lock_without_reset", dll_locked, 0);
    issue(3'd2);
    step(202);
    rd_req = 1'b0; step(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule